// File: doc/BRIEF.md
# Transmit Packet Queue Framer

This block is the transmit-side packet buffer between a host and a MAC. The host streams 16-bit words into it. Each frame is a header of two words followed by its payload. The first header word is a control word. The second word holds the payload length in bytes. The payload words follow immediately after. Frames are stored back to back in one shared memory of 4 KB (2048 words), so several frames can wait while an earlier one is still being sent.

On the MAC side the block sends each stored frame as a byte stream. The header is stripped, so only payload bytes leave, and the last byte is flagged. A status group describes the frame that is currently on the wire. This need not be the frame most recently queued. It shows the frame's control word, its effective length and a CRC-append enable taken from bit 0 of the control word. A one-cycle done pulse marks the end of each frame. The CRC generator and the MAC itself lie outside this block.

Both data interfaces use valid/ready. A word or byte moves only in a cycle where valid and ready are both high. A source that raises valid must hold it and its data until ready is seen. The block keeps `m_data` and `m_last` steady while `m_valid` is high and `m_ready` is low. It lowers `s_ready` rather than overwrite unread data.

Top module: `tx_frame_queue`

## Requirements
- R1: Per frame, the host writes the control word, then the length word, then ceil(L/2) payload words, where L is the effective length. Payload byte 2k is carried in bits 7:0 of payload word k, and byte 2k+1 in bits 15:8. These bytes leave on `m_data` in ascending order.
- R2: Only payload bytes reach the MAC side, and exactly L of them per frame. `m_last` is high on the final byte only, and frames leave in the order they were written.
- R3: When L is odd, bits 15:8 of the final payload word are padding. They are never sent, and the next frame's header is read from the following word.
- R4: The effective length L is the length word clamped into the range 1 to 1916. A length word of 0 acts as 1, and anything above 1916 acts as 1916. The writer and the reader both use L.
- R5: `s_ready` is low whenever all 2048 words are occupied. A word is stored only when `s_valid` and `s_ready` are both high, so no unread word is ever overwritten.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data` and `m_last` stay unchanged in the next cycle.
- R7: `frame_avail` is high while at least one fully written frame has not finished sending. A frame's first byte is never offered before its last payload word has been written.
- R8: `free_words` equals 2048 minus the number of words that are written but not yet consumed. It reads 2048 after reset and again once the queue has drained.
- R9: While a frame is being sent, `stat_busy` is high. In that time `stat_ctrl` shows that frame's control word, `stat_len` shows its L, and `crc_en` equals bit 0 of its control word.
- R10: `done` pulses for exactly one cycle, in the cycle after the handshake of a frame's last byte. During that pulse `stat_ctrl` and `stat_len` still describe the finished frame.
- R11: After reset, `s_ready` is 1 while `m_valid`, `frame_avail`, `done` and `stat_busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Host word valid |
| s_ready | output | 1 | Queue can accept a word |
| s_data | input | 16 | Host word (control, length, or payload) |
| m_valid | output | 1 | MAC byte valid |
| m_ready | input | 1 | MAC accepts the byte |
| m_data | output | 8 | Payload byte |
| m_last | output | 1 | Final byte of the frame |
| frame_avail | output | 1 | At least one complete frame is pending |
| free_words | output | 12 | Unoccupied 16-bit words |
| stat_busy | output | 1 | A frame is being sent |
| stat_ctrl | output | 16 | Control word of the frame being sent |
| stat_len | output | 11 | Effective length of the frame being sent |
| crc_en | output | 1 | CRC append requested for the frame being sent |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions check the per-cycle rules on every cycle:
- MAC-side data stays stable under back-pressure.
- Input is refused when the queue is full.
- No byte is offered without a complete frame.
- `done` appears after, and only after, a last-byte handshake.
- `free_words` stays within bounds.

Some behaviours can only be shown by the bench's scenarios, because they depend on frame content and history. These are:
- byte order and header stripping;
- odd-length padding;
- length clamping;
- status contents per frame;
- lossless recovery after the memory has filled with the MAC stalled.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [1:0] {WR_CTRL, WR_LEN, WR_DATA} wr_state_t;
  typedef enum logic [1:0] {RD_IDLE, RD_LEN, RD_DATA} rd_state_t;

  // Effective payload length: a zero count acts as one byte, a count
  // beyond the ceiling acts as the ceiling.
  function automatic logic [15:0] clamp_len(input logic [15:0] n, input logic [15:0] ceiling);
    if (n == 16'd0) return 16'd1;
    if (n > ceiling) return ceiling;
    return n;
  endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  input  logic          rd_adv,
  output logic [15:0]   rd_data,
  output logic [PW-1:0] used
);
  logic [15:0]   mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en)  wptr <= wptr + PW'(1);
      if (rd_adv) rptr <= rptr + PW'(1);
    end
  end

  assign rd_data = mem[rptr[AW-1:0]];
  assign used    = wptr - rptr;
endmodule

// File: rtl/txq_wr_ctrl.sv
module txq_wr_ctrl
  import txq_pkg::*;
#(
  parameter int MAX_LEN = 1916,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  input  logic        s_ready,
  input  logic [15:0] s_data,
  output logic        wr_en,
  output logic        commit
);
  wr_state_t   st;
  logic [LW-1:0] rem;
  logic [15:0]   eff, nwords;

  always_comb begin
    eff    = clamp_len(s_data, 16'(MAX_LEN));
    nwords = (eff + 16'd1) >> 1;
  end

  assign wr_en  = s_valid && s_ready;
  assign commit = wr_en && (st == WR_DATA) && (rem == LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= WR_CTRL;
      rem <= '0;
    end else if (wr_en) begin
      case (st)
        WR_CTRL: st <= WR_LEN;
        WR_LEN: begin
          rem <= nwords[LW-1:0];
          st  <= WR_DATA;
        end
        default: begin
          rem <= rem - LW'(1);
          if (rem == LW'(1)) st <= WR_CTRL;
        end
      endcase
    end
  end
endmodule

// File: rtl/txq_rd_framer.sv
module txq_rd_framer
  import txq_pkg::*;
#(
  parameter int MAX_LEN = 1916,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frames_nz,
  input  logic [15:0]   rd_data,
  output logic          rd_adv,
  output logic          fin,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [7:0]    m_data,
  output logic          m_last,
  output logic          busy,
  output logic [15:0]   stat_ctrl,
  output logic [LW-1:0] stat_len,
  output logic          done
);
  rd_state_t     st;
  logic [LW-1:0] idx;
  logic [15:0]   eff;
  logic          hs;

  always_comb begin
    eff     = clamp_len(rd_data, 16'(MAX_LEN));
    m_valid = (st == RD_DATA);
    m_data  = idx[0] ? rd_data[15:8] : rd_data[7:0];
    m_last  = m_valid && (idx == stat_len - LW'(1));
    hs      = m_valid && m_ready;
    fin     = hs && m_last;
    rd_adv  = ((st == RD_IDLE) && frames_nz) || (st == RD_LEN) ||
              (hs && (m_last || idx[0]));
  end

  assign busy = (st != RD_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= RD_IDLE;
      idx       <= '0;
      stat_ctrl <= '0;
      stat_len  <= '0;
      done      <= 1'b0;
    end else begin
      done <= fin;
      case (st)
        RD_IDLE: if (frames_nz) begin
          stat_ctrl <= rd_data;
          st        <= RD_LEN;
        end
        RD_LEN: begin
          stat_len <= eff[LW-1:0];
          idx      <= '0;
          st       <= RD_DATA;
        end
        default: if (hs) begin
          idx <= idx + LW'(1);
          if (m_last) st <= RD_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/tx_frame_queue.sv
module tx_frame_queue #(
  parameter int MEM_BYTES = 4096,
  parameter int MAX_LEN   = 1916,
  parameter int CRC_BIT   = 0,
  localparam int DEPTH = MEM_BYTES / 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1,
  localparam int LW    = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [15:0]   s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [7:0]    m_data,
  output logic          m_last,
  output logic          frame_avail,
  output logic [PW-1:0] free_words,
  output logic          stat_busy,
  output logic [15:0]   stat_ctrl,
  output logic [LW-1:0] stat_len,
  output logic          crc_en,
  output logic          done
);
  logic          wr_en, commit, rd_adv, fin;
  logic [15:0]   rd_data;
  logic [PW-1:0] used, frames;

  assign s_ready     = (used != PW'(DEPTH));
  assign free_words  = PW'(DEPTH) - used;
  assign frame_avail = (frames != '0);
  assign crc_en      = stat_busy && stat_ctrl[CRC_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) frames <= '0;
    else case ({commit, fin})
      2'b10:   frames <= frames + PW'(1);
      2'b01:   frames <= frames - PW'(1);
      default: frames <= frames;
    endcase
  end

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(s_data),
    .rd_adv(rd_adv), .rd_data(rd_data), .used(used)
  );

  txq_wr_ctrl #(.MAX_LEN(MAX_LEN)) u_wr (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .wr_en(wr_en), .commit(commit)
  );

  txq_rd_framer #(.MAX_LEN(MAX_LEN)) u_rd (
    .clk(clk), .rst_n(rst_n), .frames_nz(frame_avail), .rd_data(rd_data),
    .rd_adv(rd_adv), .fin(fin), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .busy(stat_busy),
    .stat_ctrl(stat_ctrl), .stat_len(stat_len), .done(done)
  );
endmodule

// File: rtl/txq_checks.sv
module txq_checks #(
  parameter int DEPTH = 2048,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [7:0]    m_data,
  input logic          m_last,
  input logic          frame_avail,
  input logic [PW-1:0] free_words,
  input logic          stat_busy,
  input logic          done
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (free_words == '0) |-> !s_ready); // R5
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_words <= PW'(DEPTH)); // R8
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R6
  AST_NO_EARLY_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> frame_avail); // R7
  AST_BUSY_WHILE_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> stat_busy); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> done); // R10
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(m_valid && m_ready && m_last)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind tx_frame_queue txq_checks #(.DEPTH(DEPTH)) u_checks (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
  .frame_avail(frame_avail), .free_words(free_words),
  .stat_busy(stat_busy), .done(done)
);

// File: tb/tx_frame_queue_test.sv
module tx_frame_queue_test;
  localparam int DEPTH = 2048;
  localparam int MAXL  = 1916;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic m_ready = 1'b0;
  logic s_ready, m_valid, m_last, frame_avail, stat_busy, crc_en, done;
  logic [7:0] m_data;
  logic [11:0] free_words;
  logic [15:0] stat_ctrl;
  logic [10:0] stat_len;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int mode = 0;          // 0 always ready, 1 stalled, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;

  logic [8:0]  exp_b[$];  // {last, byte}
  logic [31:0] exp_f[$];  // {ctrl, length}

  always #4 clk = ~clk;

  tx_frame_queue uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_last(m_last), .frame_avail(frame_avail), .free_words(free_words),
    .stat_busy(stat_busy), .stat_ctrl(stat_ctrl), .stat_len(stat_len),
    .crc_en(crc_en), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] eff_len(input logic [15:0] n);
    if (n == 0) return 16'd1;
    if (n > MAXL) return 16'(MAXL);
    return n;
  endfunction

  function automatic logic [7:0] pbyte(input int seed, input int i);
    return 8'((seed * 37 + i) ^ (i >> 8));
  endfunction

  // called at a negedge; returns at the negedge after the word was taken
  task automatic put_word(input logic [15:0] w);
    s_data  = w;
    s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_frame(input logic [15:0] ctrl, input logic [15:0] cnt, input int seed);
    int n = int'(eff_len(cnt));
    exp_f.push_back({ctrl, 16'(n)});
    for (int i = 0; i < n; i++) exp_b.push_back({(i == n - 1), pbyte(seed, i)});
  endtask

  function automatic logic [15:0] pword(input logic [15:0] cnt, input int seed, input int w);
    int n = int'(eff_len(cnt));
    logic [7:0] hi = (2 * w + 1 < n) ? pbyte(seed, 2 * w + 1) : 8'hEE; // R3 pad
    return {hi, pbyte(seed, 2 * w)};
  endfunction

  // R1 R4: header, then ceil(L/2) payload words
  task automatic send_frame(input logic [15:0] ctrl, input logic [15:0] cnt, input int seed);
    int nw = (int'(eff_len(cnt)) + 1) / 2;
    expect_frame(ctrl, cnt, seed);
    put_word(ctrl);
    put_word(cnt);
    for (int w = 0; w < nw; w++) put_word(pword(cnt, seed, w));
    s_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_b.size() != 0 || exp_f.size() != 0 || stat_busy) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // scoreboard monitor
  bit first_byte = 1'b1;
  bit prev_stall = 1'b0;
  bit prev_last_hs = 1'b0;
  logic [7:0] hold_d;
  logic hold_l;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_stall)
        check(m_valid && m_data == hold_d && m_last == hold_l, "R6 stall hold",
              {23'd0, m_valid, m_data}, {23'd1, hold_d});
      if (done) begin
        check(prev_last_hs, "R10 done follows last byte", 32'(done), 32'(prev_last_hs));
        if (exp_f.size() == 0) check(1'b0, "R2 unexpected frame end", 32'd1, 32'd0);
        else begin
          check({stat_ctrl, 5'd0, stat_len} == exp_f[0], "R10 status at done",
                {stat_ctrl, 5'd0, stat_len}, exp_f[0]);
          void'(exp_f.pop_front());
        end
        first_byte = 1'b1;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : lfsr[0];
      prev_last_hs = 1'b0;
      if (m_valid && m_ready) begin
        if (first_byte && exp_f.size() != 0) begin
          check(stat_busy && {stat_ctrl, 5'd0, stat_len} == exp_f[0], "R9 status on wire",
                {stat_ctrl, 5'd0, stat_len}, exp_f[0]);
          check(crc_en == exp_f[0][16], "R9 crc_en", 32'(crc_en), 32'(exp_f[0][16]));
          first_byte = 1'b0;
        end
        if (exp_b.size() == 0) check(1'b0, "R2 extra byte", {23'd0, m_last, m_data}, 32'd0);
        else begin
          check({m_last, m_data} == exp_b[0], "R1 R2 R3 byte",
                {23'd0, m_last, m_data}, {23'd0, exp_b[0]});
          void'(exp_b.pop_front());
        end
        prev_last_hs = m_last;
      end
      prev_stall = m_valid && !m_ready;
      hold_d = m_data;
      hold_l = m_last;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 R8 reset state
    check(s_ready && !m_valid && !frame_avail && !done && !stat_busy, "R11 reset outputs",
          {27'd0, s_ready, m_valid, frame_avail, done, stat_busy}, 32'h10);
    check(free_words == 12'(DEPTH), "R8 free after reset", 32'(free_words), DEPTH);

    // R7: a partly written frame is never started
    mode = 0;
    expect_frame(16'h0001, 16'd5, 1);
    put_word(16'h0001);
    put_word(16'd5);
    put_word(pword(16'd5, 1, 0));
    put_word(pword(16'd5, 1, 1));
    s_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(!m_valid && !frame_avail, "R7 partial frame held",
          {30'd0, m_valid, frame_avail}, 32'd0);
    check(free_words == 12'(DEPTH - 4), "R8 occupancy", 32'(free_words), DEPTH - 4);
    put_word(pword(16'd5, 1, 2));
    s_valid = 1'b0;
    drain();

    // varied lengths with random back-pressure: R1 R2 R3 R4 R6 R9
    mode = 2;
    send_frame(16'h0000, 16'd1, 2);
    send_frame(16'h8001, 16'd2, 3);
    send_frame(16'h0001, 16'd3, 4);
    send_frame(16'h0000, 16'd0, 5);     // R4 zero acts as one
    send_frame(16'h0041, 16'd64, 6);
    send_frame(16'h00A1, 16'(MAXL), 7);
    send_frame(16'h0000, 16'd3000, 8);  // R4 clamp to ceiling
    send_frame(16'h0001, 16'd7, 9);
    drain();
    check(free_words == 12'(DEPTH), "R8 free after drain", 32'(free_words), DEPTH);
    check(!frame_avail, "R7 no frame after drain", 32'(frame_avail), 32'd0);

    // R5: fill the memory with the MAC stalled, then release
    mode = 1;
    fork
      begin
        send_frame(16'h0001, 16'(MAXL), 10);
        send_frame(16'h0000, 16'(MAXL), 11);
        send_frame(16'h0001, 16'(MAXL), 12);
      end
    join_none
    begin
      int guard = 0;
      while (free_words != 0 && guard < 5000) begin
        @(negedge clk);
        guard++;
      end
    end
    repeat (2) @(negedge clk);
    check(free_words == 0, "R5 queue full", 32'(free_words), 32'd0);
    check(!s_ready, "R5 s_ready low when full", 32'(s_ready), 32'd0);
    check(frame_avail && !m_valid || frame_avail, "R7 full frames pending", 32'(frame_avail), 32'd1);
    mode = 2;
    wait fork;
    drain();
    check(free_words == 12'(DEPTH) && !frame_avail, "R8 R7 final drain",
          {19'd0, free_words, frame_avail}, {19'd0, 12'(DEPTH), 1'b0});
    check(exp_b.size() == 0, "R2 all bytes delivered", 32'(exp_b.size()), 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule